// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is one counter channel of a general-purpose timer. The counter is 16 bits wide and counts up. Software programs it through a plain register port: single-cycle writes and combinational reads. A mode register sets four things:

- where count pulses come from;
- whether a match with the limit register restarts the count at zero;
- whether that match also halts the channel;
- how the waveform pin reacts to each of three events: a match with the mark register, a match with the limit register, and a software restart.

Two typical uses follow from this. A periodic interrupt uses the reload mode, or a one-shot delay adds the halt bit. A free-running timebase drives a square wave on the pin.

Count pulses can come from the system clock divided by 2, 8, 32 or 128. They can also come from a slow clock input or from one of three external inputs. Each such source is turned into a one-cycle count enable in the system clock domain, so the block has a single clock.

Event flags are sticky. Reading the status register clears them. The interrupt line is high while any flag that is set is also unmasked.

The register port has no back-pressure. Every write is accepted in the cycle it is presented. Read data is valid in the same cycle as `reg_rd`. Only a read of the status register has a side effect.

Top module: `tmr_wave_channel`

## Requirements
- R1: After reset the count is 0, the pin `tioa` is 0, the channel is stopped, the status register (word 5) reads 0, the mask (word 8) reads 0 and `irq` is 0.
- R2: Source field MODE[2:0] selects the count pulses. Values 0, 1, 2 and 3 give one pulse every 2, 8, 32 or 128 system clocks. Value 4 gives one pulse per rising edge of `slow_clk_in`. Values 5, 6 and 7 give one pulse per rising edge of `ext_clk_in[0]`, `[1]` and `[2]`.
- R3: Writing the command register (word 0) with bit0 set starts the channel and with bit1 set stops it. Stop wins when both bits are written together. Status bit3 shows the running state.
- R4: Command bit2 is a software restart. It sets the count to 0 on that clock edge and applies the restart action to `tioa`. It overrides a count pulse in the same cycle, and it leaves the running state unchanged.
- R5: With MODE[4]=0 the counter passes through 0xFFFF, wraps to 0 and sets status bit0. A match with the limit register does not reset the count.
- R6: With MODE[4]=1, a count pulse that arrives while the count equals the limit register (word 3) loads 0, giving a period of limit+1 pulses.
- R7: A count pulse that arrives while the count equals the mark register (word 2) sets status bit1. One that arrives while the count equals the limit register sets status bit2. This holds in both modes.
- R8: With MODE[3]=1, a limit match stops the channel after that pulse's update. Later pulses leave the count unchanged until a start command, after which counting resumes from the held value.
- R9: `tioa` actions are 2-bit codes: 0 keep, 1 drive high, 2 drive low, 3 invert. The mark action is MODE[6:5], the limit action MODE[8:7] and the restart action MODE[10:9]. When events coincide, only the action of the highest-priority event is applied, in the order restart, then limit, then mark.
- R10: Reading word 5 returns {tioa, running, flags[2:0]} in bits [4:0] and clears the flags. A flag raised in the same cycle as that read stays set.
- R11: Writing word 6 sets mask bits where the data has ones, and writing word 7 clears them. Word 8 reads the mask in bits [2:0]. `irq` is the OR of flags ANDed with the mask.
- R12: Words 1, 2 and 3 (mode, mark, limit) read back what was written, with the mode in bits [10:0]. Word 4 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_in | input | 1 | Slow clock used as a count source |
| ext_clk_in | input | 3 | External count source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on word 5) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| tioa | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall into one cycle.

- **Restart against a count pulse.** The bench raises an external source so that its synchronised pulse lands on the same edge as a restart command. The count must read 0 and the pin must take the restart action, not the compare action.
- **Status read against a new event.** A status read is placed on the edge where a limit match occurs. The value returned must show the old flags. A second read must show only the new limit flag.

Random command, mode and pulse sequences are judged against a pulse-level model in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MARK  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT = 4'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MSET  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MCLR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd8;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_HIGH = 2'd1,
    PIN_LOW  = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  typedef struct packed {
    pin_act_e   trg_act;
    pin_act_e   lim_act;
    pin_act_e   mark_act;
    logic       reload;
    logic       stop_lim;
    logic [2:0] src;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam int NUM_EV = 3;
  localparam int EV_OVF = 0;
  localparam int EV_MARK = 1;
  localparam int EV_LIM = 2;

  function automatic logic pin_next(input pin_act_e act, input logic cur);
    case (act)
      PIN_HIGH: pin_next = 1'b1;
      PIN_LOW:  pin_next = 1'b0;
      PIN_FLIP: pin_next = ~cur;
      default:  pin_next = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src,
  input  logic             slow_in,
  input  logic [N_EXT-1:0] ext_in,
  output logic             tick
);
  localparam int N_DIV   = 4;
  localparam int PRE_W   = 2 * N_DIV - 1;
  localparam int N_ASYNC = N_EXT + 1;

  logic [PRE_W-1:0]   pre_q;
  logic [N_DIV-1:0]   div_prev;
  logic [N_DIV-1:0]   div_tick;
  logic [N_ASYNC-1:0] a_in, a_s1, a_s2, a_s3, a_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // divisor 2^(2k+1) taken from prescaler bit 2k
  for (genvar k = 0; k < N_DIV; k++) begin : g_div
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_prev[k] <= 1'b0;
      else        div_prev[k] <= pre_q[2*k];
    end
    assign div_tick[k] = pre_q[2*k] & ~div_prev[k];

    // R2
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick[k] |=> !div_tick[k]);
  end

  assign a_in = {ext_in, slow_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= '0;
      a_s2 <= '0;
      a_s3 <= '0;
    end else begin
      a_s1 <= a_in;
      a_s2 <= a_s1;
      a_s3 <= a_s2;
    end
  end
  assign a_tick = a_s2 & ~a_s3;

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < N_DIV; k++)
      if (src == 3'(k)) tick = div_tick[k];
    for (int i = 0; i < N_ASYNC; i++)
      if (src == 3'(i + N_DIV)) tick = a_tick[i];
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              cmd_trig,
  input  mode_t             mode,
  input  logic [CW-1:0]     mark,
  input  logic [CW-1:0]     limit,
  output logic [CW-1:0]     cnt,
  output logic              running,
  output logic              tioa,
  output logic [NUM_EV-1:0] ev
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          adv, hit_mark, hit_lim, wrap_zero;
  logic [CW-1:0] cnt_d;
  logic          run_d, tioa_d;

  always_comb begin
    adv       = tick & running & ~cmd_trig;
    hit_mark  = adv & (cnt == mark);
    hit_lim   = adv & (cnt == limit);
    wrap_zero = hit_lim & mode.reload;

    ev          = '0;
    ev[EV_OVF]  = adv & ~wrap_zero & (cnt == CNT_MAX);
    ev[EV_MARK] = hit_mark;
    ev[EV_LIM]  = hit_lim;

    cnt_d = cnt;
    if (cmd_trig)       cnt_d = '0;
    else if (wrap_zero) cnt_d = '0;
    else if (adv)       cnt_d = cnt + 1'b1;

    run_d = running;
    if (cmd_off || (hit_lim && mode.stop_lim)) run_d = 1'b0;
    else if (cmd_on)                           run_d = 1'b1;

    tioa_d = tioa;
    if (cmd_trig)      tioa_d = pin_next(mode.trg_act, tioa);
    else if (hit_lim)  tioa_d = pin_next(mode.lim_act, tioa);
    else if (hit_mark) tioa_d = pin_next(mode.mark_act, tioa);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      tioa    <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      running <= run_d;
      tioa    <= tioa_d;
    end
  end

  // R4
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trig |=> (cnt == '0));
  // R3
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !running);
  // R8
  lim_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_LIM] && mode.stop_lim) |=> !running);
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_LIM] && mode.reload) |=> (cnt == '0));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cmd_trig) |=> $stable(cnt));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rd_clr,
  input  logic [NUM_EV-1:0] mask_set,
  input  logic [NUM_EV-1:0] mask_clr,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (rd_clr ? '0 : flags) | ev;
      mask  <= (mask | mask_set) & ~mask_clr;
    end
  end

  assign irq = |(flags & mask);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flags & $past(ev)) == $past(ev)));
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (ev == '0)) |=> (flags == '0));
  // R11
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_clr) |=> (mask == '0));
endmodule

// File: rtl/tmr_wave_channel.sv
module tmr_wave_channel
  import tmr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int N_EXT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_in,
  input  logic [N_EXT-1:0]  ext_clk_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  output logic              tioa,
  output logic              irq
);
  localparam int STAT_W = NUM_EV + 2;

  mode_t             mode_q;
  logic [CW-1:0]     mark_q, limit_q, cnt;
  logic              tick, running;
  logic [NUM_EV-1:0] ev, flags, mask;
  logic              wr_cmd, rd_stat;
  logic [NUM_EV-1:0] mset, mclr;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);
  assign mset    = (reg_wr && reg_addr == A_MSET) ? reg_wdata[NUM_EV-1:0] : '0;
  assign mclr    = (reg_wr && reg_addr == A_MCLR) ? reg_wdata[NUM_EV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mark_q  <= '0;
      limit_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE:  mode_q  <= mode_t'(reg_wdata[MODE_W-1:0]);
        A_MARK:  mark_q  <= reg_wdata;
        A_LIMIT: limit_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  tmr_tick_sel #(.N_EXT(N_EXT)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (mode_q.src),
    .slow_in (slow_clk_in),
    .ext_in  (ext_clk_in),
    .tick    (tick)
  );

  tmr_count_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_on   (wr_cmd & reg_wdata[0]),
    .cmd_off  (wr_cmd & reg_wdata[1]),
    .cmd_trig (wr_cmd & reg_wdata[2]),
    .mode     (mode_q),
    .mark     (mark_q),
    .limit    (limit_q),
    .cnt      (cnt),
    .running  (running),
    .tioa     (tioa),
    .ev       (ev)
  );

  tmr_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .rd_clr   (rd_stat),
    .mask_set (mset),
    .mask_clr (mclr),
    .flags    (flags),
    .mask     (mask),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:  reg_rdata = {{(CW-MODE_W){1'b0}}, mode_q};
      A_MARK:  reg_rdata = mark_q;
      A_LIMIT: reg_rdata = limit_q;
      A_COUNT: reg_rdata = cnt;
      A_STAT:  reg_rdata = {{(CW-STAT_W){1'b0}}, tioa, running, flags};
      A_MASK:  reg_rdata = {{(CW-NUM_EV){1'b0}}, mask};
      default: reg_rdata = '0;
    endcase
  end

  // R11
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|mask));
endmodule

// File: tb/tmr_wave_channel_test.sv
module tmr_wave_channel_test;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk_in = 1'b0;
  logic [2:0]  ext_clk_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tioa, irq;

  always #5 clk = ~clk;

  tmr_wave_channel uut (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow_clk_in), .ext_clk_in(ext_clk_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tioa(tioa), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // pulse-level reference model
  logic [15:0] m_cnt, m_mark, m_lim;
  logic [10:0] m_mode;
  logic        m_run, m_tioa;
  logic [2:0]  m_flags, m_mask;

  function automatic logic act(input logic [1:0] a, input logic cur);
    case (a)
      2'd1: act = 1'b1;
      2'd2: act = 1'b0;
      2'd3: act = ~cur;
      default: act = cur;
    endcase
  endfunction

  function automatic logic [15:0] mk_mode(input int src, input int stp, input int rld,
                                          input int ma, input int la, input int ta);
    mk_mode = 16'((ta << 9) | (la << 7) | (ma << 5) | (rld << 4) | (stp << 3) | src);
  endfunction

  task automatic m_tick();
    logic hm, hl;
    if (!m_run) return;
    hm = (m_cnt == m_mark);
    hl = (m_cnt == m_lim);
    if (hm) m_flags[1] = 1'b1;
    if (hl) m_flags[2] = 1'b1;
    if (hl && m_mode[4]) m_cnt = 16'd0;
    else begin
      if (m_cnt == 16'hFFFF) m_flags[0] = 1'b1;
      m_cnt = m_cnt + 16'd1;
    end
    if (hl) m_tioa = act(m_mode[8:7], m_tioa);
    else if (hm) m_tioa = act(m_mode[6:5], m_tioa);
    if (hl && m_mode[3]) m_run = 1'b0;
  endtask

  task automatic m_trig();
    m_cnt = 16'd0;
    m_tioa = act(m_mode[10:9], m_tioa);
  endtask

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      A_MODE:  m_mode = d[10:0];
      A_MARK:  m_mark = d;
      A_LIMIT: m_lim = d;
      A_MSET:  m_mask = m_mask | d[2:0];
      A_MCLR:  m_mask = m_mask & ~d[2:0];
      A_CMD: begin
        if (d[2]) m_trig();
        if (d[1]) m_run = 1'b0;
        else if (d[0]) m_run = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == A_STAT) m_flags = 3'b000;
  endtask

  // one external pulse on ext_clk_in[0]; tick consumed on 3rd edge
  task automatic ext_pulse(input int coll, output logic [15:0] d);
    d = '0;
    @(negedge clk); ext_clk_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (coll == 1) begin reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 16'd4; end
    if (coll == 2) begin reg_rd = 1'b1; reg_addr = A_STAT; #1 d = reg_rdata; end
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; ext_clk_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (coll == 1) m_trig();
    else begin
      if (coll == 2) m_flags = 3'b000;
      m_tick();
    end
  endtask

  task automatic ticks(input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) ext_pulse(0, d);
  endtask

  task automatic check_model(input string req);
    logic [15:0] d;
    rd(A_COUNT, d);
    chk(d == m_cnt, req, d, m_cnt);
    chk(tioa == m_tioa, req, tioa, m_tioa);
    chk(irq == |(m_flags & m_mask), req, irq, |(m_flags & m_mask));
  endtask

  initial begin : watchdog
    for (int c = 0; c < 199000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d, d2;
    void'($urandom(32'd1234));
    m_cnt = 0; m_mark = 0; m_lim = 0; m_mode = 0; m_run = 0; m_tioa = 0;
    m_flags = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, d);  chk(d == 0, "R1 status", d, 0);
    rd(A_COUNT, d); chk(d == 0, "R1 count", d, 0);
    rd(A_MASK, d);  chk(d == 0, "R1 mask", d, 0);
    chk(tioa == 0, "R1 tioa", tioa, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R12 readback
    wr(A_MODE, mk_mode(5, 0, 1, 1, 2, 1));
    wr(A_MARK, 16'd2);
    wr(A_LIMIT, 16'd6);
    rd(A_MODE, d);  chk(d == mk_mode(5, 0, 1, 1, 2, 1), "R12 mode", d, mk_mode(5, 0, 1, 1, 2, 1));
    rd(A_MARK, d);  chk(d == 2, "R12 mark", d, 2);
    rd(A_LIMIT, d); chk(d == 6, "R12 limit", d, 6);

    // R3 stop wins over start
    wr(A_CMD, 16'd3);
    rd(A_STAT, d); chk(d[3] == 0, "R3 stop wins", d[3], 0);
    wr(A_CMD, 16'd1);
    rd(A_STAT, d); chk(d[3] == 1, "R3 start", d[3], 1);

    // R6 R7 R9 reload period with mark set / limit clear
    wr(A_CMD, 16'd4);
    chk(tioa == 1, "R4 restart action", tioa, 1);
    ticks(7);
    rd(A_COUNT, d); chk(d == 0, "R6 reload to zero", d, 0);
    chk(tioa == 0, "R9 limit clears pin", tioa, 0);
    rd(A_STAT, d); chk(d[4:0] == 5'h0E, "R7 mark+limit flags", d[4:0], 5'h0E);

    // R4 restart colliding with a count pulse
    ticks(3);
    rd(A_COUNT, d); chk(d == 3, "R4 pre", d, 3);
    ext_pulse(1, d);
    rd(A_COUNT, d); chk(d == 0, "R4 restart beats pulse", d, 0);
    chk(tioa == 1, "R4 pin on collision", tioa, 1);
    ticks(1);
    rd(A_COUNT, d); chk(d == 1, "R4 counts after restart", d, 1);

    // R8 stop on limit
    wr(A_MODE, mk_mode(5, 1, 1, 0, 0, 0));
    wr(A_MARK, 16'd7);
    wr(A_LIMIT, 16'd2);
    wr(A_CMD, 16'd5);
    ticks(3);
    rd(A_STAT, d); chk(d[3] == 0, "R8 halted", d[3], 0);
    ticks(2);
    rd(A_COUNT, d); chk(d == 0, "R8 pulses ignored", d, 0);
    wr(A_CMD, 16'd1);
    ticks(1);
    rd(A_COUNT, d); chk(d == 1, "R8 resume", d, 1);

    // R9 priority limit over mark, then invert
    wr(A_MODE, mk_mode(5, 0, 1, 1, 2, 1));
    wr(A_MARK, 16'd1);
    wr(A_LIMIT, 16'd1);
    wr(A_CMD, 16'd4);
    ticks(2);
    chk(tioa == 0, "R9 limit beats mark", tioa, 0);
    rd(A_COUNT, d); chk(d == 0, "R9 count", d, 0);
    wr(A_MODE, mk_mode(5, 0, 1, 2, 3, 0));
    ticks(2);
    chk(tioa == 1, "R9 invert", tioa, 1);

    // R10 read colliding with a new limit event
    wr(A_MODE, mk_mode(5, 0, 1, 0, 0, 0));
    wr(A_MARK, 16'd1);
    wr(A_LIMIT, 16'd3);
    rd(A_STAT, d);
    wr(A_CMD, 16'd4);
    ticks(3);
    ext_pulse(2, d);
    chk(d[2:0] == 3'b010, "R10 read returns old flags", d[2:0], 3'b010);
    m_flags[2] = 1'b1;
    rd(A_STAT, d); chk(d[2:0] == 3'b100, "R10 new flag survives read", d[2:0], 3'b100);

    // R11 masking
    wr(A_MSET, 16'd4);
    rd(A_MASK, d); chk(d == 4, "R11 mask set", d, 4);
    ticks(2);
    chk(irq == 0, "R11 masked mark", irq, 0);
    ticks(2);
    chk(irq == 1, "R11 limit irq", irq, 1);
    wr(A_MCLR, 16'hFF);
    chk(irq == 0, "R11 irq off", irq, 0);
    rd(A_MASK, d); chk(d == 0, "R11 mask clear", d, 0);

    // R2 slow clock source
    wr(A_MODE, mk_mode(4, 0, 0, 0, 0, 0));
    wr(A_LIMIT, 16'hF000);
    wr(A_CMD, 16'd5);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) slow_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    rd(A_COUNT, d); chk(d == 10, "R2 slow clock", d, 10);

    // R2 divided clocks
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CMD, 16'd5);
    repeat (64) @(negedge clk);
    rd(A_COUNT, d); chk(d >= 30 && d <= 35, "R2 div2", d, 32);
    wr(A_MODE, mk_mode(3, 0, 0, 0, 0, 0));
    wr(A_CMD, 16'd5);
    repeat (1280) @(negedge clk);
    rd(A_COUNT, d); chk(d >= 9 && d <= 11, "R2 div128", d, 10);
    wr(A_MODE, mk_mode(1, 0, 0, 0, 0, 0));
    wr(A_CMD, 16'd5);
    repeat (160) @(negedge clk);
    rd(A_COUNT, d); chk(d >= 19 && d <= 21, "R2 div8", d, 20);

    // random sequences against the model
    wr(A_MODE, mk_mode(5, 0, 1, 0, 0, 0));
    wr(A_CMD, 16'd6);
    rd(A_STAT, d);
    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 10;
      if (r <= 5) ticks(1);
      else if (r == 6) wr(A_CMD, 16'(4 | ($urandom % 2)));
      else if (r == 7) wr(A_CMD, 16'($urandom % 4));
      else if (r == 8) begin
        wr(A_MODE, mk_mode(5, ($urandom % 4) == 0, ($urandom % 4) != 0,
                           $urandom % 4, $urandom % 4, $urandom % 4));
        wr(A_MARK, 16'($urandom % 12));
        wr(A_LIMIT, 16'($urandom % 12));
        wr(A_MSET, 16'($urandom % 8));
        wr(A_MCLR, 16'($urandom % 8));
      end else begin
        d2 = {11'd0, m_tioa, m_run, m_flags};
        rd(A_STAT, d);
        chk(d == d2, "R10 random status", d, d2);
      end
      check_model("R6 R7 R8 R9 random");
    end

    // R5 free run: limit does not reset, wraps with overflow flag
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_LIMIT, 16'd5);
    wr(A_MARK, 16'h0100);
    rd(A_STAT, d);
    wr(A_CMD, 16'd5);
    repeat (100) @(negedge clk);
    rd(A_COUNT, d); chk(d > 16'd40 && d < 16'd60, "R5 no reset at limit", d, 50);
    rd(A_STAT, d); chk(d[0] == 0, "R5 no early overflow", d[0], 0);
    repeat (131072) @(negedge clk);
    rd(A_COUNT, d); chk(d > 16'd40 && d < 16'd70, "R5 wrap", d, 52);
    rd(A_STAT, d); chk(d[0] == 1, "R5 overflow flag", d[0], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule